// File: doc/BRIEF.md
# Pixel-Scan Gated Clock Generator

This block produces the timing clocks for an image sensor that is read out serially, one pixel at a time. A base clock runs continuously. While scanning is enabled, the block counts it in a repeating period of 32 cycles, one period per pixel. Three gated clocks are derived from that count: a load clock, a shift clock and a pixel clock. Each one copies the base-clock high phase only in the cycles of its own window and stays low in every other cycle. The current cycle index and a pixel-done strobe are also brought out, so that surrounding logic can follow the scan position.

The gated outputs are built so that they cannot produce runt pulses. Each window is decoded from the value the counter will take at the next rising edge. That decode is captured in a register on the falling edge of the base clock and then ANDed with the clock. The gate enable therefore only changes while the base clock is low. Every pulse that reaches an output is a complete half period wide: 100 ns for the nominal 200 ns base clock.

All pins are plain control and clock signals. The block has no data stream, so it has no valid/ready handshake. When scanning is re-enabled, or reset is released, the next base-clock cycle is cycle 0 of a new period.

Top module: `pixscan_clkgen`

## Requirements
- R1: While scanning is active, `cycle_idx` advances by one on each base-clock rising edge, runs from 0 to 31 and wraps from 31 back to 0. The first active cycle after enabling is index 0.
- R2: `load_clk` carries the base-clock high phase in cycles 0 to 5 of each period and is low in cycles 6 to 31, giving 6 pulses per period.
- R3: `shift_clk` carries exactly one base-clock high phase per period, in cycle 8, and is low in every other cycle.
- R4: `pix_clk` carries the base-clock high phase in cycles 15 to 30 inclusive and is low in cycles 0 to 14 and in cycle 31, giving 16 pulses per period.
- R5: While `scan_en` is low, all three gated clocks stay low, `cycle_idx` holds at 0 and `pixel_done` is low. After `scan_en` returns high, the following cycle is cycle 0 with a load pulse.
- R6: Synchronous reset `rst` (active high, sampled on the rising edge) has priority over `scan_en`. It forces the same idle state as R5, and the period restarts at cycle 0 after release.
- R7: `pixel_done` is high during cycle 31 of each active period and low in every other cycle.
- R8: A gate enable changes only while the base clock is low. Every high pulse on a gated output lasts a full base-clock half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (nominal 200 ns period) |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan enable; low puts the block in idle |
| load_clk | output | 1 | Gated load clock, cycles 0 to 5 |
| shift_clk | output | 1 | Gated shift clock, cycle 8 |
| pix_clk | output | 1 | Gated pixel clock, cycles 15 to 30 |
| cycle_idx | output | 5 | Current cycle index within the pixel period |
| pixel_done | output | 1 | High during the last cycle of each period |

## Verification
On every rising edge, the assertions check the counter's step and wrap and the idle state forced by a low enable. They also check that the shift enable never lasts two cycles, that the load window is the one opening as the period ends, and that a gate enable never moves while the base clock is high. The exact window edges, the pulse counts of 6, 1 and 16 per period, and the full width of each gated pulse are shown only by the bench's scenarios. The same holds for the restart at cycle 0 after a mid-period disable or reset. The bench measures these with its own edge counters and pulse-width timers.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_GATES = 3;
  localparam int GATE_LOAD  = 0;
  localparam int GATE_SHIFT = 1;
  localparam int GATE_PIX   = 2;
endpackage

// File: rtl/scan_cycle_counter.sv
module scan_cycle_counter #(
  parameter int PERIOD = 32,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_en,
  output logic [CW-1:0] count,
  output logic          active,
  output logic [CW-1:0] nxt_count,
  output logic          nxt_active
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_comb begin
    if (rst || !scan_en) begin
      nxt_count  = '0;
      nxt_active = 1'b0;
    end else if (!active) begin
      nxt_count  = '0;
      nxt_active = 1'b1;
    end else begin
      nxt_count  = (count == LAST) ? '0 : count + 1'b1;
      nxt_active = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    count  <= nxt_count;
    active <= nxt_active;
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (active && scan_en && count != LAST) |=> (count == $past(count) + 1'b1));

  assert_count_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (active && scan_en && count == LAST) |=> (count == '0 && active));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!scan_en) |=> (count == '0 && !active));
endmodule

// File: rtl/scan_window_decode.sv
module scan_window_decode #(
  parameter int PERIOD = 32,
  parameter int FIRST  = 0,
  parameter int LAST   = 0,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic [CW-1:0] nxt_count,
  input  logic          nxt_active,
  output logic          gate_en
);
  logic in_window;

  always_comb begin
    in_window = nxt_active && (int'(nxt_count) >= FIRST) && (int'(nxt_count) <= LAST);
  end

  // Captured while the base clock is low, ahead of the rising edge it serves.
  always_ff @(negedge clk) begin
    gate_en <= in_window;
  end
endmodule

// File: rtl/scan_clock_gate.sv
module scan_clock_gate (
  input  logic clk_in,
  input  logic gate_en,
  output logic gclk
);
  assign gclk = clk_in & gate_en;

  always @(gate_en) begin
    assert_gate_moves_low_R8: assert (clk_in == 1'b0)
      else $error("gate enable changed while base clock high");
  end
endmodule

// File: rtl/pixscan_clkgen.sv
module pixscan_clkgen #(
  parameter int PERIOD      = 32,
  parameter int LOAD_FIRST  = 0,
  parameter int LOAD_LAST   = 5,
  parameter int SHIFT_CYCLE = 8,
  parameter int PIX_FIRST   = 15,
  parameter int PIX_LAST    = 30,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_en,
  output logic          load_clk,
  output logic          shift_clk,
  output logic          pix_clk,
  output logic [CW-1:0] cycle_idx,
  output logic          pixel_done
);
  import scan_pkg::*;

  localparam int WIN_FIRST [NUM_GATES] = '{LOAD_FIRST, SHIFT_CYCLE, PIX_FIRST};
  localparam int WIN_LAST  [NUM_GATES] = '{LOAD_LAST,  SHIFT_CYCLE, PIX_LAST};

  logic          active;
  logic          nxt_active;
  logic [CW-1:0] nxt_count;
  logic [NUM_GATES-1:0] gate_en;
  logic [NUM_GATES-1:0] gclk;

  scan_cycle_counter #(.PERIOD(PERIOD)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .count     (cycle_idx),
    .active    (active),
    .nxt_count (nxt_count),
    .nxt_active(nxt_active)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    scan_window_decode #(
      .PERIOD(PERIOD), .FIRST(WIN_FIRST[g]), .LAST(WIN_LAST[g])
    ) u_decode (
      .clk       (clk),
      .nxt_count (nxt_count),
      .nxt_active(nxt_active),
      .gate_en   (gate_en[g])
    );

    scan_clock_gate u_gate (
      .clk_in (clk),
      .gate_en(gate_en[g]),
      .gclk   (gclk[g])
    );
  end

  assign load_clk   = gclk[GATE_LOAD];
  assign shift_clk  = gclk[GATE_SHIFT];
  assign pix_clk    = gclk[GATE_PIX];
  assign pixel_done = active && (cycle_idx == CW'(PERIOD - 1));

  assert_idle_gates_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!scan_en) |-> (gate_en == '0));

  assert_shift_single_R3: assert property (@(posedge clk) disable iff (rst)
    gate_en[GATE_SHIFT] |=> !gate_en[GATE_SHIFT]);

  assert_done_then_load_R7: assert property (@(posedge clk) disable iff (rst)
    (pixel_done && scan_en) |-> (gate_en[GATE_LOAD] && !gate_en[GATE_PIX]));
endmodule

// File: tb/test_pixscan_clkgen.sv
`timescale 1ns/1ps
module test_pixscan_clkgen;
  localparam int CLK_NS = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_en = 1'b0;
  logic load_clk, shift_clk, pix_clk, pixel_done;
  logic [4:0] cycle_idx;

  int checks = 0;
  int errors = 0;
  int n_load = 0, n_shift = 0, n_pix = 0, runts = 0;
  realtime t_load, t_shift, t_pix;

  always #(CLK_NS/2) clk = ~clk;

  pixscan_clkgen i_pixscan_clkgen (
    .clk(clk), .rst(rst), .scan_en(scan_en),
    .load_clk(load_clk), .shift_clk(shift_clk), .pix_clk(pix_clk),
    .cycle_idx(cycle_idx), .pixel_done(pixel_done)
  );

  // Pulse counters and width timers (R8)
  always @(posedge load_clk)  begin n_load++;  t_load  = $realtime; end
  always @(posedge shift_clk) begin n_shift++; t_shift = $realtime; end
  always @(posedge pix_clk)   begin n_pix++;   t_pix   = $realtime; end
  always @(negedge load_clk)  if ($realtime - t_load  < CLK_NS/2 - 1) runts++;
  always @(negedge shift_clk) if ($realtime - t_shift < CLK_NS/2 - 1) runts++;
  always @(negedge pix_clk)   if ($realtime - t_pix   < CLK_NS/2 - 1) runts++;

  // {cycle, load, shift, pix, done}
  localparam logic [8:0] VEC [0:13] = '{
    {5'd0,  4'b1000}, {5'd1,  4'b1000}, {5'd4,  4'b1000}, {5'd5,  4'b1000},
    {5'd6,  4'b0000}, {5'd7,  4'b0000}, {5'd8,  4'b0100}, {5'd9,  4'b0000},
    {5'd12, 4'b0000}, {5'd14, 4'b0000}, {5'd15, 4'b0010}, {5'd22, 4'b0010},
    {5'd30, 4'b0010}, {5'd31, 4'b0001}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_NS/4);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " idx"}, cycle_idx, 0);
    chk({tag, " gates"}, {load_clk, shift_clk, pix_clk}, 0);
    chk({tag, " done"}, pixel_done, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl, bs, bp;
    repeat (3) tick();
    chk_idle("R6 reset state");

    rst = 1'b0; scan_en = 1'b1;
    bl = n_load; bs = n_shift; bp = n_pix;
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 32; c++) begin
        tick();
        chk("R1 cycle index", cycle_idx, c);
        for (int v = 0; v < 14; v++) begin
          if (int'(VEC[v][8:4]) == c) begin
            chk("R2 load window",  load_clk,   VEC[v][3]);
            chk("R3 shift window", shift_clk,  VEC[v][2]);
            chk("R4 pix window",   pix_clk,    VEC[v][1]);
            chk("R7 pixel done",   pixel_done, VEC[v][0]);
          end
        end
        if (c == 31) begin
          chk("R2 load pulses per period",  n_load - bl,  6);
          chk("R3 shift pulses per period", n_shift - bs, 1);
          chk("R4 pix pulses per period",   n_pix - bp,   16);
          bl = n_load; bs = n_shift; bp = n_pix;
        end
      end
    end

    // Mid-period disable (R5)
    for (int c = 0; c < 10; c++) tick();
    chk("R1 index before disable", cycle_idx, 9);
    scan_en = 1'b0;
    tick();
    chk_idle("R5 disabled");
    bl = n_load; bs = n_shift; bp = n_pix;
    repeat (4) tick();
    chk_idle("R5 still disabled");
    chk("R5 no pulses while idle", (n_load - bl) + (n_shift - bs) + (n_pix - bp), 0);
    scan_en = 1'b1;
    tick();
    chk("R5 restart index", cycle_idx, 0);
    chk("R5 restart load pulse", load_clk, 1);

    // Mid-period reset with enable held (R6)
    for (int c = 0; c < 20; c++) tick();
    chk("R1 index before reset", cycle_idx, 20);
    chk("R4 pix mid window", pix_clk, 1);
    rst = 1'b1;
    tick();
    chk_idle("R6 reset over enable");
    rst = 1'b0;
    tick();
    chk("R6 restart index", cycle_idx, 0);
    chk("R6 restart load pulse", load_clk, 1);
    tick();
    chk("R1 step after restart", cycle_idx, 1);

    chk("R8 runt pulses", runts, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule